// File: doc/BRIEF.md
# Configuration Memory Address Sequencer

This block is the control and address-counter logic of a configuration memory that streams stored words to an FPGA, one word per clock. It keeps the read address presented to the storage array and decides when the data pins may drive. It also drives the chip-enable that hands the stream to the next device in a daisy chain, and it reports the power state. The storage array itself sits outside the block.

Up to four revision banks can be defined, each with its own first and last address. When revisions are enabled, a 2-bit select picks the bank. Reset and a configuration pulse then return the address to that bank's first word, and the counter parks on its last word. When revisions are disabled, the counter starts at zero and runs to the terminal count, which is the highest address.

A busy input from the FPGA stalls the stream. It is honoured only when the device is set for parallel output with decompression off.

Top module: `cfg_addr_seq`

## Requirements
- R1: With `rst_ni` high, `ce_ni` low, `cfg_ni` high and no effective busy, `addr_o` increments by one per rising clock edge. This happens while it is below `TERM_COUNT` and not parked at the bank's last address. In this state `data_oe_o`=1, `next_ce_no`=1, `clk_oe_o`=1 and `pwr_o`=ACTIVE (2'b01).
- R2: When `addr_o` equals `TERM_COUNT`, the address stops changing, `data_oe_o`=0, `next_ce_no`=0, `clk_oe_o`=0 and `pwr_o`=REDUCED (2'b10). This takes priority over R3 when a bank's last address equals `TERM_COUNT`.
- R3: With `rev_en_i`=1, when `addr_o` equals the selected bank's last address and that address is below `TERM_COUNT`, the address holds, `data_oe_o`=0, `next_ce_no`=1, `clk_oe_o`=0 and `pwr_o`=REDUCED.
- R4: While `rst_ni` is low and `ce_ni` is low, the address is held at the reset value immediately (asynchronously), `data_oe_o`=0, `next_ce_no`=1, `clk_oe_o`=0 and `pwr_o`=ACTIVE.
- R5: While `ce_ni` is high, the address is held at the reset value immediately, whatever the other inputs are; `data_oe_o`=0, `next_ce_no`=1, `clk_oe_o`=0 and `pwr_o`=STANDBY (2'b00).
- R6: With `par_mode_i`=1 and `decomp_en_i`=0, `busy_i` high at a rising edge during counting leaves `addr_o` unchanged, with `data_oe_o`=1, `next_ce_no`=1 and `clk_oe_o`=1.
- R7: `cfg_ni` low at a rising edge (while enabled) returns the address to the reset value, regardless of `busy_i`. The reset value is the selected bank's first address when `rev_en_i`=1 and 0 otherwise.
- R8: With `par_mode_i`=0 or `decomp_en_i`=1, `busy_i` has no effect and counting proceeds as in R1.
- R9: Bank b (b=0..3, chosen by `bank_sel_i`=b) takes its first address from `BANK_FIRST[b*ADDR_W +: ADDR_W]` and its last address from `BANK_LAST[b*ADDR_W +: ADDR_W]`. Both must be at or below `TERM_COUNT`. `bank_sel_i` and `rev_en_i` only change while the block is held in reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Configuration clock, rising edge |
| rst_ni | input | 1 | Output enable / asynchronous address reset, active low |
| ce_ni | input | 1 | Chip enable, active low; high selects standby |
| cfg_ni | input | 1 | Configuration restart pulse, active low, sampled |
| busy_i | input | 1 | Stall request from the FPGA, sampled |
| par_mode_i | input | 1 | 1 = parallel data output mode |
| decomp_en_i | input | 1 | 1 = decompression active (busy ignored) |
| rev_en_i | input | 1 | 1 = revision banks in use |
| bank_sel_i | input | 2 | Selected revision bank |
| addr_o | output | ADDR_W | Read address to the storage array |
| data_oe_o | output | 1 | Data pins drive when 1, high impedance when 0 |
| next_ce_no | output | 1 | Chip enable for the next chained device, active low |
| clk_oe_o | output | 1 | Clock output active when 1 |
| pwr_o | output | 2 | Power state: 00 standby, 01 active, 10 reduced |

## Verification
The counter is driven with long runs without revisions, so it reaches the terminal count and the chain hand-off can be told apart from a bank stop. It is also run through every bank, including one whose last address equals the terminal count, which separates the priority of the two stop conditions. Random busy, restart, reset and enable pulses are laid over the counting. A reference model predicts the effect of each one, and in serial or decompressing modes it treats busy as ignored. Directed cases cover the standby and held-reset power codes, and a restart issued while busy.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [1:0] {
    PWR_STANDBY = 2'b00,
    PWR_ACTIVE  = 2'b01,
    PWR_REDUCED = 2'b10
  } pwr_e;
endpackage

// File: rtl/cfg_bank_table.sv
module cfg_bank_table #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned SEL_W     = 2,
  parameter logic [NUM_BANKS*ADDR_W-1:0] BANK_FIRST = '0,
  parameter logic [NUM_BANKS*ADDR_W-1:0] BANK_LAST  = '0
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              rev_en_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] last_o
);
  logic [ADDR_W-1:0] first_tbl [NUM_BANKS];
  logic [ADDR_W-1:0] last_tbl  [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign first_tbl[b] = BANK_FIRST[b*ADDR_W +: ADDR_W];
    assign last_tbl[b]  = BANK_LAST[b*ADDR_W +: ADDR_W];
  end

  // without revisions the stream always starts at word 0
  assign base_o = rev_en_i ? first_tbl[sel_i] : '0;
  assign last_o = last_tbl[sel_i];
endmodule

// File: rtl/cfg_addr_cnt.sv
module cfg_addr_cnt #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              arst_ni,
  input  logic              clr_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] off_q;

  // offset from bank base: async clear needs no data-dependent reset value
  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)   off_q <= '0;
    else if (clr_i) off_q <= '0;
    else if (adv_i) off_q <= off_q + ADDR_W'(1);
  end

  assign addr_o = base_i + off_q;

  AST_CLR_TO_BASE: assert property (@(posedge clk_i) disable iff (!arst_ni)
    clr_i |=> addr_o == base_i); // R7
endmodule

// File: rtl/cfg_out_ctrl.sv
module cfg_out_ctrl
  import cfg_seq_pkg::*;
(
  input  logic       ce_ni,
  input  logic       rst_ni,
  input  logic       at_tc_i,
  input  logic       at_last_i,
  output logic       data_oe_o,
  output logic       next_ce_no,
  output logic       clk_oe_o,
  output logic [1:0] pwr_o
);
  pwr_e pwr;

  always_comb begin
    data_oe_o  = 1'b0;
    next_ce_no = 1'b1;
    clk_oe_o   = 1'b0;
    pwr        = PWR_ACTIVE;
    if (ce_ni) begin
      pwr = PWR_STANDBY;
    end else if (!rst_ni) begin
      pwr = PWR_ACTIVE;
    end else if (at_tc_i) begin
      next_ce_no = 1'b0;
      pwr        = PWR_REDUCED;
    end else if (at_last_i) begin
      pwr = PWR_REDUCED;
    end else begin
      data_oe_o = 1'b1;
      clk_oe_o  = 1'b1;
    end
  end

  assign pwr_o = pwr;

  always_comb begin
    AST_STANDBY_QUIET: assert (!ce_ni || (!data_oe_o && next_ce_no && pwr_o == 2'b00)); // R5
    AST_NO_DRIVE_WHILE_HANDOFF: assert (next_ce_no || !data_oe_o); // R2
  end
endmodule

// File: rtl/cfg_addr_seq.sv
module cfg_addr_seq
  import cfg_seq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned NUM_BANKS  = 4,
  parameter int unsigned TERM_COUNT = 200,
  parameter logic [NUM_BANKS*ADDR_W-1:0] BANK_FIRST = {8'd150, 8'd100, 8'd50, 8'd0},
  parameter logic [NUM_BANKS*ADDR_W-1:0] BANK_LAST  = {8'd180, 8'd200, 8'd90, 8'd40},
  localparam int unsigned SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              cfg_ni,
  input  logic              busy_i,
  input  logic              par_mode_i,
  input  logic              decomp_en_i,
  input  logic              rev_en_i,
  input  logic [SEL_W-1:0]  bank_sel_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              data_oe_o,
  output logic              next_ce_no,
  output logic              clk_oe_o,
  output logic [1:0]        pwr_o
);
  localparam logic [ADDR_W-1:0] TC = ADDR_W'(TERM_COUNT);

  logic              arst_n;
  logic [ADDR_W-1:0] base, last;
  logic              at_tc, at_last, busy_eff, adv;

  assign arst_n   = rst_ni & ~ce_ni;
  assign busy_eff = busy_i & par_mode_i & ~decomp_en_i;
  assign at_tc    = (addr_o == TC);
  assign at_last  = rev_en_i & (addr_o == last) & ~at_tc;
  assign adv      = cfg_ni & ~busy_eff & ~at_tc & ~at_last;

  cfg_bank_table #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .SEL_W(SEL_W),
    .BANK_FIRST(BANK_FIRST), .BANK_LAST(BANK_LAST)
  ) u_banks (
    .sel_i(bank_sel_i), .rev_en_i(rev_en_i), .base_o(base), .last_o(last)
  );

  cfg_addr_cnt #(.ADDR_W(ADDR_W)) u_cnt (
    .clk_i(clk_i), .arst_ni(arst_n), .clr_i(~cfg_ni), .adv_i(adv),
    .base_i(base), .addr_o(addr_o)
  );

  cfg_out_ctrl u_out (
    .ce_ni(ce_ni), .rst_ni(rst_ni), .at_tc_i(at_tc), .at_last_i(at_last),
    .data_oe_o(data_oe_o), .next_ce_no(next_ce_no), .clk_oe_o(clk_oe_o), .pwr_o(pwr_o)
  );

  AST_ADVANCE: assert property (@(posedge clk_i) disable iff (!arst_n)
    (cfg_ni && !(busy_i && par_mode_i && !decomp_en_i) && data_oe_o)
    |=> addr_o == $past(addr_o) + ADDR_W'(1)); // R1
  AST_PARK_TC: assert property (@(posedge clk_i) disable iff (!arst_n)
    (cfg_ni && !next_ce_no) |=> $stable(addr_o) && !next_ce_no); // R2
  AST_PARK_LAST: assert property (@(posedge clk_i) disable iff (!arst_n)
    (cfg_ni && next_ce_no && !data_oe_o) |=> $stable(addr_o) && next_ce_no); // R3
  AST_BUSY_FREEZE: assert property (@(posedge clk_i) disable iff (!arst_n)
    (cfg_ni && busy_i && par_mode_i && !decomp_en_i) |=> $stable(addr_o)); // R6
  AST_BUSY_IGNORED: assert property (@(posedge clk_i) disable iff (!arst_n)
    (cfg_ni && busy_i && (!par_mode_i || decomp_en_i) && data_oe_o)
    |=> addr_o != $past(addr_o)); // R8
endmodule

// File: tb/sim_cfg_addr_seq.sv
`timescale 1ns/1ps
module sim_cfg_addr_seq;
  localparam int AW = 8;
  localparam int TC = 200;
  localparam logic [4*AW-1:0] FIRST = {8'd150, 8'd100, 8'd50, 8'd0};
  localparam logic [4*AW-1:0] LAST  = {8'd180, 8'd200, 8'd90, 8'd40};

  logic clk = 1'b0;
  logic rst_n, ce_n, cf_n, busy, par, dec, rev;
  logic [1:0] sel;
  logic [AW-1:0] addr;
  logic oe, ceo_n, clko;
  logic [1:0] pwr;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int m_off = 0;
  bit last_cf = 1'b0, last_busy_eff = 1'b0, last_busy_ign = 1'b0;

  always #4 clk = ~clk;

  cfg_addr_seq #(.ADDR_W(AW), .NUM_BANKS(4), .TERM_COUNT(TC),
                 .BANK_FIRST(FIRST), .BANK_LAST(LAST)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .cfg_ni(cf_n), .busy_i(busy),
    .par_mode_i(par), .decomp_en_i(dec), .rev_en_i(rev), .bank_sel_i(sel),
    .addr_o(addr), .data_oe_o(oe), .next_ce_no(ceo_n), .clk_oe_o(clko), .pwr_o(pwr));

  function automatic int f_base();
    return rev ? int'(FIRST[sel*AW +: AW]) : 0;
  endfunction
  function automatic int f_last();
    return int'(LAST[sel*AW +: AW]);
  endfunction
  function automatic int f_addr();
    return (f_base() + m_off) % 256;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req_in);
    int a, e_oe, e_ceo, e_clk, e_pwr;
    string req;
    req = req_in;
    a = f_addr();
    if (ce_n) begin e_oe = 0; e_ceo = 1; e_clk = 0; e_pwr = 0; req = "R5"; end
    else if (!rst_n) begin e_oe = 0; e_ceo = 1; e_clk = 0; e_pwr = 1; req = "R4"; end
    else if (a == TC) begin e_oe = 0; e_ceo = 0; e_clk = 0; e_pwr = 2; req = "R2"; end
    else if (rev && a == f_last()) begin e_oe = 0; e_ceo = 1; e_clk = 0; e_pwr = 2; req = "R3"; end
    else begin
      e_oe = 1; e_ceo = 1; e_clk = 1; e_pwr = 1;
      if (req == "") req = last_cf ? "R7" : last_busy_eff ? "R6" : last_busy_ign ? "R8" : "R1";
    end
    if (rev && req == "R1") req = "R1/R9";
    check(req, "addr", int'(addr), a);
    check(req, "data_oe", int'(oe), e_oe);
    check(req, "next_ce_n", int'(ceo_n), e_ceo);
    check(req, "clk_oe", int'(clko), e_clk);
    check(req, "pwr", int'(pwr), e_pwr);
  endtask

  // inputs are already set (at a negedge); model one rising edge, check at next negedge
  task automatic step(string req = "");
    bit be;
    if (!rst_n || ce_n) m_off = 0;
    @(posedge clk);
    be = busy && par && !dec;
    last_cf = 1'b0; last_busy_eff = 1'b0; last_busy_ign = 1'b0;
    if (rst_n && !ce_n) begin
      if (!cf_n) begin m_off = 0; last_cf = 1'b1; end
      else if (be) last_busy_eff = 1'b1;
      else if (f_addr() < TC && !(rev && f_addr() == f_last())) begin
        m_off++;
        last_busy_ign = busy;
      end
    end
    @(negedge clk);
    check_all(req);
  endtask

  task automatic setup(bit r, bit [1:0] s, bit p, bit d);
    ce_n = 1'b1; rst_n = 1'b1; cf_n = 1'b1; busy = 1'b0;
    rev = r; sel = s; par = p; dec = d;
    step("R5");
    ce_n = 1'b0;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    ce_n = 1'b1; rst_n = 1'b0; cf_n = 1'b1; busy = 1'b0;
    par = 1'b0; dec = 1'b0; rev = 1'b0; sel = 2'd0;
    @(negedge clk);
    step("R5");                                 // reset state: standby
    ce_n = 1'b0;
    repeat (2) step("R4");                      // held reset, active power
    rst_n = 1'b1;

    // R1/R2: full run without revisions to terminal count, then park
    repeat (TC + 5) step();
    check("R2", "parked addr", int'(addr), TC);

    // R3 bank stop, then R7 restart to bank base while busy
    setup(1'b1, 2'd1, 1'b1, 1'b0);
    repeat (50) step();
    check("R3", "bank1 last", int'(addr), 90);
    busy = 1'b1; cf_n = 1'b0; step("R7");
    check("R7", "restart with busy", int'(addr), 50);
    cf_n = 1'b1; repeat (3) step("R6");
    check("R6", "busy freeze", int'(addr), 50);

    // bank 2 last == terminal count: R2 priority over R3
    busy = 1'b0;
    setup(1'b1, 2'd2, 1'b0, 1'b0);
    repeat (110) step();
    check("R2", "bank2 hand-off", int'(ceo_n), 0);

    // R8: busy ignored in serial mode and with decompression
    setup(1'b0, 2'd3, 1'b0, 1'b0);
    busy = 1'b1; repeat (4) step("R8");
    check("R8", "serial ignores busy", int'(addr), 5);
    setup(1'b0, 2'd0, 1'b1, 1'b1);
    busy = 1'b1; repeat (4) step("R8");
    check("R8", "decomp ignores busy", int'(addr), 5);
    busy = 1'b0;

    // constrained random phases
    for (int ph = 0; ph < 40; ph++) begin
      setup(1'($urandom % 2), 2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 3 == 0));
      for (int c = 0; c < 300; c++) begin
        cf_n  = ($urandom % 60) != 0;
        busy  = ($urandom % 6) == 0;
        rst_n = ($urandom % 120) != 0;
        ce_n  = ($urandom % 150) == 0;
        step();
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule